// File: doc/BRIEF.md
# Two-Frame SPI Register Transactor for an Accelerometer

This block is an SPI master that performs one register read or register write on an accelerometer per request. Every exchange with the sensor is a 32-bit full-duplex frame, and the sensor answers a command one frame late. For that reason each request produces two frames. The first carries the command. The second carries zeros on MOSI, and the sensor's reply to the command arrives on MISO during it.

The command frame is built from an operation bit, a 5-bit register address and a 16-bit write value, and it is protected by an inverted CRC-8. The reply is checked against its own CRC and its two return-status bits. Its 16-bit payload is returned sign-extended, along with separate flags for a transfer (CRC) error, a device error and a rejected address.

Chip select is held high for at least a programmable number of system clock cycles between any two frames. This covers both the two frames of one request and the last frame of one request followed by the first frame of the next. A user-side valid/ready handshake accepts requests, and a one-cycle response strobe returns the result.

Top module: `acc_spi_xactor`

## Requirements
- R1: Byte 0 of the command frame (frame bits [31:24]) is {op, addr[4:0], 2'b00}, where op=1 means write and op=0 means read. Bit 31 goes out on MOSI first.
- R2: Command bytes 1 and 2 (frame bits [23:8]) hold the write value with its high byte first. On a read they are zero.
- R3: Command byte 3 (frame bits [7:0]) is the bitwise inverse of a CRC-8 over bits [31:8]. The CRC uses polynomial 0x1D, initial value 0xFF, processes the most significant bit first, and has no reflection.
- R4: Each accepted request with a legal address produces exactly two frames. The second frame is all zeros on MOSI, and the response is taken from the bits received during the second frame.
- R5: Frames use SPI mode 0. SCLK is low whenever chip select is high. MOSI changes after falling edges and MISO is sampled on rising edges. A frame has exactly 32 SCLK rising edges, each SCLK half period lasts DIV_HALF clock cycles, and chip select stays low for exactly 64*DIV_HALF cycles.
- R6: Between any two frames, cs_no stays high for at least GAP_CYC clock cycles.
- R7: rsp_data_o is the sign extension of the received bits [23:8] (bytes 1 and 2, high byte first).
- R8: rsp_dev_err_o is set exactly when the received bits [25:24] equal 2'b11.
- R9: rsp_crc_err_o is set exactly when the received bits [7:0] differ from the inverted CRC-8 (R3 rule) of the received bits [31:8]. It is independent of rsp_dev_err_o.
- R10: A request with req_addr_i above 0x1F sends no frame. The next cycle gives a response with rsp_addr_err_o=1, rsp_data_o=0 and the other two error flags at 0.
- R11: req_ready_o is high only while the block is idle. It is low from the accept of a legal request until the trailing gap after its second frame has elapsed. Each accepted request produces exactly one single-cycle rsp_valid_o pulse.
- R12: After reset, cs_no=1, sclk_o=0, mosi_o=0, req_ready_o=1 and rsp_valid_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle and able to take a request |
| req_write_i | input | 1 | 1 = register write, 0 = register read |
| req_addr_i | input | ADDR_IN_W | Register address; values above 0x1F are rejected |
| req_wdata_i | input | 16 | Write value |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| rsp_data_o | output | DATA_W | Sign-extended returned value |
| rsp_crc_err_o | output | 1 | Reply CRC mismatch |
| rsp_dev_err_o | output | 1 | Reply return status signals device error |
| rsp_addr_err_o | output | 1 | Request rejected for address range |
| sclk_o | output | 1 | SPI clock |
| mosi_o | output | 1 | SPI data to the sensor |
| miso_i | input | 1 | SPI data from the sensor |
| cs_no | output | 1 | SPI chip select, active low |

## Verification
The properties assume that MISO is settled before each rising SCLK edge. They also assume that the request fields are valid in the cycle the request is accepted, and nowhere else. The bench's sensor model changes MISO only right after a falling SCLK edge or a chip-select fall. The bench drives request fields on falling system clock edges and holds them for exactly the accepting cycle, so a design that latched them late would be caught. Reply words are drawn at random, with chosen status bits and CRC bytes that are either correct or deliberately corrupted, so the reply decoding is exercised on both sides of every flag.

// File: rtl/acc_spi_pkg.sv
`timescale 1ns/1ps
package acc_spi_pkg;
  localparam int FRAME_W = 32;
  localparam int REG_AW  = 5;
  localparam int VAL_W   = 16;
  localparam logic [7:0] CRC_POLY = 8'h1D;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_GAP_MID,
    ST_RSP,
    ST_GAP_END
  } xact_st_e;

  // inverted CRC-8, msb first, seed 0xFF
  function automatic logic [7:0] crc8_inv(input logic [23:0] d);
    logic [7:0] c;
    logic       fb;
    c = 8'hFF;
    for (int i = 23; i >= 0; i--) begin
      fb = c[7] ^ d[i];
      c  = {c[6:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return ~c;
  endfunction

  function automatic logic [FRAME_W-1:0] build_cmd(input logic wr,
                                                   input logic [REG_AW-1:0] a,
                                                   input logic [VAL_W-1:0] wd);
    logic [23:0] h;
    h = {wr, a, 2'b00, wd};
    return {h, crc8_inv(h)};
  endfunction
endpackage

// File: rtl/acc_spi_shifter.sv
`timescale 1ns/1ps
module acc_spi_shifter #(
  parameter int DIV_HALF = 5,
  parameter int FRAME_W  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               miso_i,
  output logic               sclk_o,
  output logic               mosi_o,
  output logic               cs_no,
  output logic               done_o,
  output logic [FRAME_W-1:0] rx_o
);
  localparam int HC_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam int BC_W = $clog2(FRAME_W);

  logic               busy_q, sclk_q, done_q;
  logic [HC_W-1:0]    hcnt_q;
  logic [BC_W-1:0]    bcnt_q;
  logic [FRAME_W-1:0] tx_q, rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      done_q <= 1'b0;
      hcnt_q <= '0;
      bcnt_q <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          tx_q   <= frame_i;
          rx_q   <= '0;
          sclk_q <= 1'b0;
          hcnt_q <= '0;
          bcnt_q <= '0;
        end
      end else if (hcnt_q == HC_W'(DIV_HALF - 1)) begin
        hcnt_q <= '0;
        if (!sclk_q) begin
          sclk_q <= 1'b1;
          rx_q   <= {rx_q[FRAME_W-2:0], miso_i};
        end else begin
          sclk_q <= 1'b0;
          tx_q   <= {tx_q[FRAME_W-2:0], 1'b0};
          if (bcnt_q == BC_W'(FRAME_W - 1)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            bcnt_q <= bcnt_q + 1'b1;
          end
        end
      end else begin
        hcnt_q <= hcnt_q + 1'b1;
      end
    end
  end

  assign sclk_o = sclk_q;
  assign mosi_o = busy_q & tx_q[FRAME_W-1];
  assign cs_no  = ~busy_q;
  assign done_o = done_q;
  assign rx_o   = rx_q;
endmodule

// File: rtl/acc_spi_gap_timer.sv
`timescale 1ns/1ps
module acc_spi_gap_timer #(
  parameter int GAP_CYC = 2500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic expire_o
);
  localparam int CW = $clog2(GAP_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic          run_q, exp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      exp_q <= 1'b0;
    end else begin
      exp_q <= 1'b0;
      if (start_i) begin
        cnt_q <= '0;
        run_q <= 1'b1;
      end else if (run_q) begin
        if (cnt_q == CW'(GAP_CYC - 1)) begin
          run_q <= 1'b0;
          exp_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign expire_o = exp_q;
endmodule

// File: rtl/acc_spi_xactor.sv
`timescale 1ns/1ps
module acc_spi_xactor
  import acc_spi_pkg::*;
#(
  parameter int DIV_HALF  = 5,
  parameter int GAP_CYC   = 2500,
  parameter int ADDR_IN_W = 8,
  parameter int DATA_W    = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  output logic                 req_ready_o,
  input  logic                 req_write_i,
  input  logic [ADDR_IN_W-1:0] req_addr_i,
  input  logic [VAL_W-1:0]     req_wdata_i,
  output logic                 rsp_valid_o,
  output logic [DATA_W-1:0]    rsp_data_o,
  output logic                 rsp_crc_err_o,
  output logic                 rsp_dev_err_o,
  output logic                 rsp_addr_err_o,
  output logic                 sclk_o,
  output logic                 mosi_o,
  input  logic                 miso_i,
  output logic                 cs_no
);
  localparam int MAX_ADDR = (1 << REG_AW) - 1;

  xact_st_e           st_q;
  logic               start_q;
  logic [FRAME_W-1:0] frame_q;
  logic               sh_done, gap_exp;
  logic [FRAME_W-1:0] rx;
  logic [DATA_W-1:0]  rx_ext;
  logic               addr_bad;
  logic               rsp_valid_q, crc_err_q, dev_err_q, addr_err_q;
  logic [DATA_W-1:0]  data_q;
  logic [5:0]         unused_rx_hi;

  acc_spi_shifter #(.DIV_HALF(DIV_HALF), .FRAME_W(FRAME_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_q),
    .frame_i (frame_q),
    .miso_i  (miso_i),
    .sclk_o  (sclk_o),
    .mosi_o  (mosi_o),
    .cs_no   (cs_no),
    .done_o  (sh_done),
    .rx_o    (rx)
  );

  // every frame end restarts the idle-gap window
  acc_spi_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (sh_done),
    .expire_o (gap_exp)
  );

  generate
    if (DATA_W > VAL_W) begin : g_sext
      assign rx_ext = {{(DATA_W-VAL_W){rx[23]}}, rx[23:8]};
    end else begin : g_noext
      assign rx_ext = rx[23:8];
    end
  endgenerate

  assign unused_rx_hi = rx[31:26];
  assign addr_bad     = req_addr_i > ADDR_IN_W'(MAX_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      start_q     <= 1'b0;
      frame_q     <= '0;
      rsp_valid_q <= 1'b0;
      crc_err_q   <= 1'b0;
      dev_err_q   <= 1'b0;
      addr_err_q  <= 1'b0;
      data_q      <= '0;
    end else begin
      start_q     <= 1'b0;
      rsp_valid_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          if (addr_bad) begin
            rsp_valid_q <= 1'b1;
            addr_err_q  <= 1'b1;
            crc_err_q   <= 1'b0;
            dev_err_q   <= 1'b0;
            data_q      <= '0;
          end else begin
            frame_q <= build_cmd(req_write_i, req_addr_i[REG_AW-1:0],
                                 req_write_i ? req_wdata_i : '0);
            start_q <= 1'b1;
            st_q    <= ST_CMD;
          end
        end
        ST_CMD: if (sh_done) st_q <= ST_GAP_MID;
        ST_GAP_MID: if (gap_exp) begin
          frame_q <= '0;
          start_q <= 1'b1;
          st_q    <= ST_RSP;
        end
        ST_RSP: if (sh_done) begin
          rsp_valid_q <= 1'b1;
          addr_err_q  <= 1'b0;
          dev_err_q   <= (rx[25:24] == 2'b11);
          crc_err_q   <= (rx[7:0] != crc8_inv(rx[31:8]));
          data_q      <= rx_ext;
          st_q        <= ST_GAP_END;
        end
        ST_GAP_END: if (gap_exp) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o    = (st_q == ST_IDLE);
  assign rsp_valid_o    = rsp_valid_q;
  assign rsp_data_o     = data_q;
  assign rsp_crc_err_o  = crc_err_q;
  assign rsp_dev_err_o  = dev_err_q;
  assign rsp_addr_err_o = addr_err_q;
endmodule

// File: rtl/acc_spi_xactor_chk.sv
`timescale 1ns/1ps
module acc_spi_xactor_chk #(
  parameter int GAP_CYC   = 2500,
  parameter int ADDR_IN_W = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_valid_i,
  input logic                 req_ready_o,
  input logic [ADDR_IN_W-1:0] req_addr_i,
  input logic                 rsp_valid_o,
  input logic                 rsp_addr_err_o,
  input logic                 sclk_o,
  input logic                 cs_no
);
  localparam int GW = $clog2(GAP_CYC + 1);

  logic [GW-1:0] gap_q;
  logic [6:0]    rise_q;
  logic          sclk_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= GW'(GAP_CYC);
      rise_q <= '0;
      sclk_d <= 1'b0;
    end else begin
      sclk_d <= sclk_o;
      if (cs_no) gap_q <= (gap_q == GW'(GAP_CYC)) ? gap_q : gap_q + 1'b1;
      else       gap_q <= '0;
      if (cs_no)                 rise_q <= '0;
      else if (sclk_o && !sclk_d) rise_q <= rise_q + 1'b1;
    end
  end

  p_cs_gap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> gap_q >= GW'(GAP_CYC));

  p_sclk_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);

  p_frame_len_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> rise_q == 7'd32);

  p_addr_reject_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && req_addr_i > ADDR_IN_W'(31))
      |=> (rsp_valid_o && rsp_addr_err_o && cs_no));

  p_busy_not_ready_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_no |-> !req_ready_o);
endmodule

bind acc_spi_xactor acc_spi_xactor_chk #(
  .GAP_CYC   (GAP_CYC),
  .ADDR_IN_W (ADDR_IN_W)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_valid_i    (req_valid_i),
  .req_ready_o    (req_ready_o),
  .req_addr_i     (req_addr_i),
  .rsp_valid_o    (rsp_valid_o),
  .rsp_addr_err_o (rsp_addr_err_o),
  .sclk_o         (sclk_o),
  .cs_no          (cs_no)
);

// File: tb/acc_spi_xactor_tb.sv
`timescale 1ns/1ps
module acc_spi_xactor_tb;
  localparam int DIV_HALF = 2;
  localparam int GAP_CYC  = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, rsp_valid, crc_err, dev_err, addr_err;
  logic [31:0] rsp_data;
  logic        sclk, mosi, miso, cs_n;

  int checks = 0, errs = 0;

  always #2 clk = ~clk;

  acc_spi_xactor #(.DIV_HALF(DIV_HALF), .GAP_CYC(GAP_CYC), .ADDR_IN_W(8), .DATA_W(32)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data), .rsp_crc_err_o(crc_err),
    .rsp_dev_err_o(dev_err), .rsp_addr_err_o(addr_err),
    .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso), .cs_no(cs_n)
  );

  // sensor model
  logic [31:0] resp_word = '0, junk_word = '0;
  logic [5:0]  fall_idx = '0;
  logic [31:0] rx_sh = '0;
  int          rise_cnt = 0;
  int          fcnt = 0;
  logic [31:0] cap [2];
  int          cap_rise [2];
  int          cap_lo [2];
  int          lo_cnt = 0, hi_cnt = 100000, min_gap = 100000;
  logic [31:0] cur_word;

  assign cur_word = fcnt[0] ? resp_word : junk_word;
  assign miso = cs_n ? 1'b0 : cur_word[5'd31 - fall_idx[4:0]];

  always @(negedge sclk or posedge cs_n)
    if (cs_n) fall_idx <= '0; else fall_idx <= fall_idx + 1'b1;

  always @(posedge sclk or negedge cs_n)
    if (!sclk) begin rise_cnt <= 0; rx_sh <= '0; end
    else if (!cs_n) begin rise_cnt <= rise_cnt + 1; rx_sh <= {rx_sh[30:0], mosi}; end

  always @(posedge clk) begin
    if (!cs_n) lo_cnt <= lo_cnt + 1; else lo_cnt <= 0;
    if (cs_n) hi_cnt <= hi_cnt + 1; else hi_cnt <= 0;
  end

  always @(posedge cs_n) if (rst_n) begin
    cap[fcnt[0]]      <= rx_sh;
    cap_rise[fcnt[0]] <= rise_cnt;
    cap_lo[fcnt[0]]   <= lo_cnt;
    fcnt              <= fcnt + 1;
  end

  always @(negedge cs_n) if (hi_cnt < min_gap) min_gap <= hi_cnt;

  function automatic logic [7:0] tb_crc(input logic [23:0] m);
    logic [7:0] r;
    r = 8'hFF;
    for (int k = 0; k < 3; k++) begin
      r = r ^ m[23-8*k -: 8];
      for (int j = 0; j < 8; j++) r = r[7] ? ((r << 1) ^ 8'h1D) : (r << 1);
    end
    return ~r;
  endfunction

  function automatic logic [31:0] exp_cmd(input logic wr, input logic [4:0] a, input logic [15:0] wd);
    logic [23:0] h;
    h = {wr, a, 2'b00, (wr ? wd : 16'h0000)};
    return {h, tb_crc(h)};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic run_txn(input bit wr, input logic [4:0] a, input logic [15:0] wd,
                         input logic [1:0] st, input logic [15:0] val, input bit bad_crc);
    logic [23:0] h;
    logic [7:0]  c;
    logic [31:0] exp_d;
    int f0, n;
    h = {6'($urandom), st, val};
    c = tb_crc(h);
    if (bad_crc) c = c ^ 8'($urandom_range(1, 255));
    resp_word = {h, c};
    junk_word = $urandom;
    f0 = fcnt;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = {3'b000, a}; req_wdata = wd;
    n = 0;
    while (!req_ready && n < 5000) begin @(negedge clk); n++; end
    @(negedge clk);
    req_valid = 1'b0; req_write = $urandom; req_addr = $urandom; req_wdata = $urandom;
    chk(req_ready == 1'b0, "R11", "ready after accept", 32'(req_ready), 0);
    n = 0;
    while (!rsp_valid && n < 5000) begin @(negedge clk); n++; end
    exp_d = {{16{val[15]}}, val};
    chk(rsp_valid == 1'b1, "R11", "response strobe", 32'(rsp_valid), 1);
    chk(rsp_data == exp_d, "R7", "data", rsp_data, exp_d);
    chk(dev_err == (st == 2'b11), "R8", "device error", 32'(dev_err), 32'(st == 2'b11));
    chk(crc_err == bad_crc, "R9", "crc error", 32'(crc_err), 32'(bad_crc));
    chk(addr_err == 1'b0, "R10", "addr error on legal", 32'(addr_err), 0);
    chk(fcnt == f0 + 2, "R4", "frame count", 32'(fcnt - f0), 2);
    chk(cap[0] == exp_cmd(wr, a, wd), "R1 R2 R3", "command frame", cap[0], exp_cmd(wr, a, wd));
    chk(cap[1] == 32'h0, "R4", "second frame mosi", cap[1], 0);
    chk(cap_rise[0] == 32 && cap_rise[1] == 32, "R5", "sclk rises", 32'(cap_rise[1]), 32);
    chk(cap_lo[0] == 64*DIV_HALF && cap_lo[1] == 64*DIV_HALF, "R5", "cs low cycles",
        32'(cap_lo[0]), 32'(64*DIV_HALF));
    chk(req_ready == 1'b0, "R11", "ready in trailing gap", 32'(req_ready), 0);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R11", "single-cycle strobe", 32'(rsp_valid), 0);
    n = 0;
    while (!req_ready && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic run_bad_addr(input logic [7:0] a);
    int f0;
    f0 = fcnt;
    @(negedge clk);
    req_valid = 1'b1; req_write = $urandom; req_addr = a; req_wdata = $urandom;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid && addr_err, "R10", "addr reject strobe", {rsp_valid, addr_err}, 32'h3);
    chk(rsp_data == 0 && !crc_err && !dev_err, "R10", "reject payload", rsp_data, 0);
    chk(cs_n == 1'b1, "R10", "no chip select", 32'(cs_n), 1);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R11", "reject strobe width", 32'(rsp_valid), 0);
    repeat (10) @(negedge clk);
    chk(fcnt == f0, "R10", "no frame sent", 32'(fcnt - f0), 0);
    chk(req_ready == 1'b1, "R11", "ready after reject", 32'(req_ready), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errs++;
    $display("FAIL R11 watchdog: actual cycles %0d expected < %0d", 200000, 200000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd20240607);
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1 && sclk == 1'b0 && mosi == 1'b0, "R12", "pins in reset",
        {cs_n, sclk, mosi}, 32'h4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R12", "handshake after reset",
        {req_ready, rsp_valid}, 32'h2);
    // directed cases
    run_txn(1'b0, 5'h10, 16'hBEEF, 2'b01, 16'h0051, 1'b0);
    run_txn(1'b1, 5'h0D, 16'h0020, 2'b01, 16'h0000, 1'b0);
    run_txn(1'b0, 5'h01, 16'h0000, 2'b01, 16'h8001, 1'b0);
    run_txn(1'b0, 5'h1F, 16'h0000, 2'b11, 16'h7FFF, 1'b0);
    run_txn(1'b1, 5'h00, 16'hFFFF, 2'b10, 16'h1234, 1'b1);
    run_txn(1'b0, 5'h06, 16'h0000, 2'b11, 16'hFFFF, 1'b1);
    run_bad_addr(8'h20);
    run_bad_addr(8'hFF);
    // random mix
    for (int i = 0; i < 30; i++) begin
      if ($urandom_range(0, 7) == 0) run_bad_addr(8'($urandom_range(32, 255)));
      else run_txn(1'($urandom), 5'($urandom), 16'($urandom), 2'($urandom),
                   16'($urandom), ($urandom_range(0, 3) == 0));
    end
    chk(min_gap >= GAP_CYC, "R6", "min cs high gap", 32'(min_gap), 32'(GAP_CYC));
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end
endmodule